// File: doc/BRIEF.md
# Byte-Register Serial Port with Four-Entry Receive Queue

This block is a complete asynchronous serial port that a processor drives through eight byte-wide registers placed on word-aligned addresses. It transmits and receives 8-bit characters framed as one low start bit, eight data bits sent least significant first, and one high stop bit. There is no parity and no flow control. The bit rate comes from a 16-bit divisor. The receiver samples the line four times per bit. The transmitter holds one character at a time. The receiver keeps up to four characters in a queue, so software can take several characters on a single interrupt.

One status byte combines three kinds of information. It holds two sticky receive error flags, the queue level flags and the transmit-empty flag, and it also holds the two interrupt enables. Software clears an error flag with a read-modify-write that writes that bit as zero. A single interrupt output serves both directions. Four constant identification bytes, set by a parameter, let software recognise the block.

Top module: `mmio_uart`

## Requirements
- R1: After reset the status byte reads 0xA0, the divisor registers read the bytes of DIV_RESET, `irq` is 0 and `txOut` is 1.
- R2: Bits [4:2] of the address select the register. 0–3 are the identification bytes, where index i returns byte i of ID_WORD (bits 8i+7..8i). 4 is data, 5 is status, 6 is divisor low and 7 is divisor high. If address bits [1:0] are not zero, no register is selected: a write has no effect and a read returns 0.
- R3: The receive queue holds RX_DEPTH characters. Status bit5 is set when the queue is empty. Bit4 is set when exactly one slot is free. Bit3 is set when the queue is full. Writes cannot change these bits.
- R4: With divisor D = {high, low}, every transmitted bit lasts 4·(D+1) clock cycles. The frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. The line idles at 1.
- R5: If a character completes while the queue is full, that character is dropped and status bit1 (overrun) is set. The bit stays set until software clears it.
- R6: Status bit7 (transmit empty) goes to 0 when data is written and returns to 1 once the stop bit has been fully sent. A data write made while bit7 is 0 is ignored.
- R7: If the stop bit is sampled low, status bit0 (frame error) is set and stays set. The character is still queued.
- R8: A data read returns the oldest queued character one cycle later and removes it from the queue. A data read from an empty queue returns the last character removed and changes nothing.
- R9: Writing status bit0 or bit1 as 0 clears that flag, and writing it as 1 leaves it unchanged. Bit2 (receive interrupt enable) and bit6 (transmit interrupt enable) take the value written. Bits 3, 4, 5 and 7 ignore writes.
- R10: `irq` is 1 exactly when (bit2 is set and either the queue is non-empty or an error flag is set) or (bit6 is set and bit7 is set).
- R11: The receiver takes a falling edge as a start bit only if the line is still low two sample ticks later. A shorter low pulse queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 5 | Byte address of the register access |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, valid the cycle after `regRd` |
| txOut | output | 1 | Serial transmit line |
| rxIn | input | 1 | Serial receive line (asynchronous) |
| irq | output | 1 | Combined receive/transmit interrupt |

## Verification
The bench builds the block with the default queue depth of four, an identification word of 0x44332211 and a reset divisor of 0x0102. The non-trivial reset value shows that both divisor bytes come up correctly before the bench programs them. The bench then runs at divisors 0, 1 and 2, which means bit periods of 4, 8 and 12 clocks. Every receive byte value passes through the receiver at the fastest rate. Each transmit frame is decoded bit by bit at each of these rates. With a depth of four, every queue level, the overrun on a fifth character and the read-when-empty case can be reached in a few frames.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;
  localparam int BYTE_W     = 8;
  localparam int DIV_W      = 2 * BYTE_W;
  localparam int ADDR_W     = 5;
  localparam int OVERSAMPLE = 4;

  typedef enum logic [2:0] {
    SEL_ID0, SEL_ID1, SEL_ID2, SEL_ID3,
    SEL_DATA, SEL_STAT, SEL_DIVLO, SEL_DIVHI
  } regSel_e;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rxState_e;

  typedef struct packed {
    logic              loadTx;
    logic [BYTE_W-1:0] txByte;
    logic              popRx;
  } ctrlStrobe_t;

  typedef struct packed {
    logic              txEmpty;
    logic              rxEmpty;
    logic              rxOneLeft;
    logic              rxFull;
    logic [BYTE_W-1:0] rxHead;
    logic              frameEvt;
    logic              overrunEvt;
  } dpStatus_t;
endpackage

// File: rtl/mmio_uart_rxfifo.sv
module mmio_uart_rxfifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPush = push && (count < CNT_W'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  assert_pop_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && count != '0) |=> count == CNT_W'($past(count) - 1'b1));
endmodule

// File: rtl/mmio_uart_dp.sv
module mmio_uart_dp
  import mmio_uart_pkg::*;
#(
  parameter int RX_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  ctrlStrobe_t      strobe,
  output dpStatus_t        dpStat,
  output logic             txOut,
  input  logic             rxIn
);
  localparam int OS_W       = $clog2(OVERSAMPLE);
  localparam int BIT_W      = DIV_W + OS_W;
  localparam int FRAME_BITS = BYTE_W + 2;
  localparam int FB_W       = $clog2(FRAME_BITS);
  localparam int IDX_W      = $clog2(BYTE_W);
  localparam int CNT_W      = $clog2(RX_DEPTH + 1);

  // sample tick for the receiver: one every divisor+1 clocks
  logic [DIV_W-1:0] tickCnt;
  logic sampleTick;
  assign sampleTick = (tickCnt >= divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           tickCnt <= '0;
    else if (sampleTick) tickCnt <= '0;
    else                 tickCnt <= tickCnt + 1'b1;
  end

  // transmitter: own bit timer, restarted on every load
  logic                  txBusy;
  logic [FRAME_BITS-1:0] txShift;
  logic [FB_W-1:0]       txBitsLeft;
  logic [BIT_W-1:0]      txClk;
  logic [BIT_W-1:0]      bitLast;

  assign bitLast = {divisor, {OS_W{1'b1}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy     <= 1'b0;
      txShift    <= '1;
      txBitsLeft <= '0;
      txClk      <= '0;
    end else if (!txBusy) begin
      if (strobe.loadTx) begin
        txBusy     <= 1'b1;
        txShift    <= {1'b1, strobe.txByte, 1'b0};
        txBitsLeft <= FB_W'(FRAME_BITS - 1);
        txClk      <= '0;
      end
    end else if (txClk >= bitLast) begin
      txClk <= '0;
      if (txBitsLeft == '0) begin
        txBusy <= 1'b0;
      end else begin
        txShift    <= {1'b1, txShift[FRAME_BITS-1:1]};
        txBitsLeft <= txBitsLeft - 1'b1;
      end
    end else begin
      txClk <= txClk + 1'b1;
    end
  end

  assign txOut = txBusy ? txShift[0] : 1'b1;

  // receiver
  logic              rxMeta, rxSync;
  rxState_e          rxState;
  logic [OS_W-1:0]   rxTick;
  logic [IDX_W-1:0]  rxIdx;
  logic [BYTE_W-1:0] rxShift;
  logic              stopNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
    end
  end

  assign stopNow = sampleTick && (rxState == RX_STOP) &&
                   (rxTick == OS_W'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxIdx   <= '0;
      rxShift <= '0;
    end else if (sampleTick) begin
      case (rxState)
        RX_IDLE: begin
          if (!rxSync) begin
            rxState <= RX_START;
            rxTick  <= '0;
          end
        end
        RX_START: begin
          if (rxTick == OS_W'(OVERSAMPLE / 2 - 1)) begin
            if (!rxSync) begin
              rxState <= RX_BITS;
              rxTick  <= '0;
              rxIdx   <= '0;
            end else begin
              rxState <= RX_IDLE;
            end
          end else begin
            rxTick <= rxTick + 1'b1;
          end
        end
        RX_BITS: begin
          if (rxTick == OS_W'(OVERSAMPLE - 1)) begin
            rxShift <= {rxSync, rxShift[BYTE_W-1:1]};
            rxTick  <= '0;
            if (rxIdx == IDX_W'(BYTE_W - 1)) rxState <= RX_STOP;
            else                              rxIdx   <= rxIdx + 1'b1;
          end else begin
            rxTick <= rxTick + 1'b1;
          end
        end
        RX_STOP: begin
          if (rxTick == OS_W'(OVERSAMPLE - 1)) rxState <= RX_IDLE;
          else                                 rxTick  <= rxTick + 1'b1;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // receive queue
  logic [CNT_W-1:0]  fifoCount;
  logic [BYTE_W-1:0] fifoHead;
  logic fifoFull, fifoPush, fifoPop;

  assign fifoFull = (fifoCount == CNT_W'(RX_DEPTH));
  assign fifoPush = stopNow && !fifoFull;
  assign fifoPop  = strobe.popRx;

  mmio_uart_rxfifo #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) uFifo (
    .clk(clk), .rstN(rstN),
    .push(fifoPush), .pushData(rxShift),
    .pop(fifoPop), .head(fifoHead), .count(fifoCount)
  );

  always_comb begin
    dpStat.txEmpty    = !txBusy;
    dpStat.rxEmpty    = (fifoCount == '0);
    dpStat.rxOneLeft  = (fifoCount == CNT_W'(RX_DEPTH - 1));
    dpStat.rxFull     = fifoFull;
    dpStat.rxHead     = fifoHead;
    dpStat.frameEvt   = stopNow && !rxSync;
    dpStat.overrunEvt = stopNow && fifoFull;
  end

  assert_tx_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTx && dpStat.txEmpty) |=> !dpStat.txEmpty);

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTx && dpStat.txEmpty) |=> !txOut);

  assert_drop_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dpStat.overrunEvt && !strobe.popRx) |=> dpStat.rxFull);
endmodule

// File: rtl/mmio_uart_ctrl.sv
module mmio_uart_ctrl
  import mmio_uart_pkg::*;
#(
  parameter logic [31:0]      ID_WORD   = 32'h0000_0000,
  parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output ctrlStrobe_t       strobe,
  input  dpStatus_t         dpStat,
  output logic [DIV_W-1:0]  divisor,
  output logic              irq
);
  logic              aligned;
  regSel_e           sel;
  logic [BYTE_W-1:0] divLo, divHi, lastByte, statusByte, readMux;
  logic              rxIe, txIe, frameErr, overErr;
  logic              wrStat, wrData, rdData;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign sel     = regSel_e'(regAddr[ADDR_W-1:2]);
  assign wrStat  = regWr && aligned && (sel == SEL_STAT);
  assign wrData  = regWr && aligned && (sel == SEL_DATA);
  assign rdData  = regRd && aligned && (sel == SEL_DATA);
  assign divisor = {divHi, divLo};

  assign statusByte = {dpStat.txEmpty, txIe, dpStat.rxEmpty, dpStat.rxOneLeft,
                       dpStat.rxFull, rxIe, overErr, frameErr};

  always_comb begin
    strobe.loadTx = wrData;
    strobe.txByte = regWrData;
    strobe.popRx  = rdData && !dpStat.rxEmpty;
  end

  always_comb begin
    readMux = '0;
    if (aligned) begin
      case (sel)
        SEL_ID0:   readMux = ID_WORD[7:0];
        SEL_ID1:   readMux = ID_WORD[15:8];
        SEL_ID2:   readMux = ID_WORD[23:16];
        SEL_ID3:   readMux = ID_WORD[31:24];
        SEL_DATA:  readMux = dpStat.rxEmpty ? lastByte : dpStat.rxHead;
        SEL_STAT:  readMux = statusByte;
        SEL_DIVLO: readMux = divLo;
        SEL_DIVHI: readMux = divHi;
        default:   readMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLo     <= DIV_RESET[BYTE_W-1:0];
      divHi     <= DIV_RESET[DIV_W-1:BYTE_W];
      rxIe      <= 1'b0;
      txIe      <= 1'b0;
      frameErr  <= 1'b0;
      overErr   <= 1'b0;
      lastByte  <= '0;
      regRdData <= '0;
    end else begin
      frameErr <= (wrStat ? (frameErr & regWrData[0]) : frameErr) | dpStat.frameEvt;
      overErr  <= (wrStat ? (overErr & regWrData[1]) : overErr) | dpStat.overrunEvt;
      if (wrStat) begin
        rxIe <= regWrData[2];
        txIe <= regWrData[6];
      end
      if (regWr && aligned && sel == SEL_DIVLO) divLo <= regWrData;
      if (regWr && aligned && sel == SEL_DIVHI) divHi <= regWrData;
      if (strobe.popRx) lastByte <= dpStat.rxHead;
      if (regRd) regRdData <= readMux;
    end
  end

  assign irq = (rxIe && (!dpStat.rxEmpty || frameErr || overErr)) ||
               (txIe && dpStat.txEmpty);

  assert_over_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    dpStat.overrunEvt |=> overErr);

  assert_frame_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    dpStat.frameEvt |=> frameErr);

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !(wrStat && !regWrData[0])) |=> frameErr);

  assert_irq_tx_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txIe && dpStat.txEmpty) |-> irq);
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int               RX_DEPTH  = 4,
  parameter logic [31:0]      ID_WORD   = 32'h0000_0000,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              txOut,
  input  logic              rxIn,
  output logic              irq
);
  ctrlStrobe_t      strobe;
  dpStatus_t        dpStat;
  logic [DIV_W-1:0] divisor;

  mmio_uart_ctrl #(.ID_WORD(ID_WORD), .DIV_RESET(DIV_RESET)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .dpStat(dpStat), .divisor(divisor), .irq(irq)
  );

  mmio_uart_dp #(.RX_DEPTH(RX_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .divisor(divisor),
    .strobe(strobe), .dpStat(dpStat), .txOut(txOut), .rxIn(rxIn)
  );
endmodule

// File: tb/sim_mmio_uart.sv
module sim_mmio_uart;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam logic [31:0] IDW  = 32'h4433_2211;
  localparam logic [15:0] DIVR = 16'h0102;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       txOut;
  logic       rxIn = 1'b1;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mmio_uart #(.RX_DEPTH(DEPTH), .ID_WORD(IDW), .DIV_RESET(DIVR)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .txOut(txOut),
    .rxIn(rxIn), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdData;
  endtask

  function automatic logic [7:0] st(input bit txE, input bit txIeB, input int cnt,
                                    input bit rxIeB, input bit ovrB, input bit ferB);
    return {txE, txIeB, cnt == 0, cnt == DEPTH - 1, cnt == DEPTH, rxIeB, ovrB, ferB};
  endfunction

  task automatic setDiv(input int d);
    wr(5'd24, 8'(d));
    wr(5'd28, 8'(d >> 8));
  endtask

  task automatic sendRx(input logic [7:0] b, input logic stopBit, input int d);
    int bp;
    logic [9:0] fr;
    bp = 4 * (d + 1);
    fr = {stopBit, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      rxIn = fr[k];
      repeat (bp - 1) @(negedge clk);
    end
    @(negedge clk);
    rxIn = 1'b1;
    repeat (2 * bp) @(negedge clk);
  endtask

  task automatic txFrame(input logic [7:0] b, input int d);
    int bp;
    logic [9:0] got;
    logic [7:0] s;
    bp = 4 * (d + 1);
    wr(5'd16, b);
    repeat (bp / 2 - 1) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      got[k] = txOut;
      if (k < 9) repeat (bp) @(negedge clk);
    end
    chk(got === {1'b1, b, 1'b0}, "R4 tx frame", {22'd0, got}, {22'd0, 1'b1, b, 1'b0});
    rd(5'd20, s);
    chk(s[7] == 1'b0, "R6 tx empty low in stop bit", s[7], 0);
    repeat (bp) @(negedge clk);
    rd(5'd20, s);
    chk(s[7] == 1'b1, "R6 tx empty after stop", s[7], 1);
    chk(txOut == 1'b1, "R4 line idle high", txOut, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] vals [4];
    logic [9:0] got;
    vals[0] = 8'h5A; vals[1] = 8'h11; vals[2] = 8'h22; vals[3] = 8'h33;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(txOut == 1'b1, "R1 txOut", txOut, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rd(5'd20, v); chk(v == 8'hA0, "R1 status", v, 8'hA0);
    rd(5'd24, v); chk(v == DIVR[7:0], "R1 div low", v, DIVR[7:0]);
    rd(5'd28, v); chk(v == DIVR[15:8], "R1 div high", v, DIVR[15:8]);

    // R2 identification bytes and divisor access
    for (int i = 0; i < 4; i++) begin
      rd(5'(4 * i), v);
      chk(v == IDW[8*i +: 8], "R2 id byte", v, IDW[8*i +: 8]);
    end
    wr(5'd24, 8'h34); wr(5'd28, 8'h12);
    rd(5'd24, v); chk(v == 8'h34, "R2 div low write", v, 8'h34);
    rd(5'd28, v); chk(v == 8'h12, "R2 div high write", v, 8'h12);

    // R4/R6 transmit sweep over divisors
    for (int d = 0; d < 3; d++) begin
      setDiv(d);
      txFrame(8'h00, d); txFrame(8'hFF, d); txFrame(8'hA5, d);
      txFrame(8'h3C, d); txFrame(8'h01, d); txFrame(8'h80, d);
    end

    // R6 write while busy is ignored
    setDiv(0);
    wr(5'd16, 8'h0F);
    wr(5'd16, 8'hF0);
    for (int k = 0; k < 10; k++) begin
      got[k] = txOut;
      if (k < 9) repeat (4) @(negedge clk);
    end
    chk(got === {1'b1, 8'h0F, 1'b0}, "R6 busy write ignored", {22'd0, got}, {22'd0, 1'b1, 8'h0F, 1'b0});
    repeat (8) @(negedge clk);

    // R10 transmit interrupt
    wr(5'd20, 8'h40);
    chk(irq == 1'b1, "R10 tx irq idle", irq, 1);
    wr(5'd16, 8'h55);
    chk(irq == 1'b0, "R10 tx irq busy", irq, 0);
    repeat (44) @(negedge clk);
    chk(irq == 1'b1, "R10 tx irq after frame", irq, 1);
    wr(5'd20, 8'h00);
    chk(irq == 1'b0, "R10 tx irq disabled", irq, 0);

    // R3/R5/R8 receive queue at divisor 1
    setDiv(1);
    wr(5'd20, 8'h04);
    chk(irq == 1'b0, "R10 rx irq empty", irq, 0);
    rd(5'd20, v); chk(v == st(1, 0, 0, 1, 0, 0), "R9 rx enable", v, st(1, 0, 0, 1, 0, 0));
    for (int i = 0; i < 4; i++) begin
      sendRx(vals[i], 1'b1, 1);
      rd(5'd20, v); chk(v == st(1, 0, i + 1, 1, 0, 0), "R3 level flags", v, st(1, 0, i + 1, 1, 0, 0));
      chk(irq == 1'b1, "R10 rx irq data", irq, 1);
    end
    sendRx(8'hEE, 1'b1, 1);
    rd(5'd20, v); chk(v == st(1, 0, 4, 1, 1, 0), "R5 overrun", v, st(1, 0, 4, 1, 1, 0));
    for (int i = 0; i < 4; i++) begin
      rd(5'd16, v); chk(v == vals[i], "R8 pop order", v, vals[i]);
    end
    rd(5'd16, v); chk(v == 8'h33, "R8 empty read", v, 8'h33);
    rd(5'd20, v); chk(v == st(1, 0, 0, 1, 1, 0), "R8 empty read no change", v, st(1, 0, 0, 1, 1, 0));
    chk(irq == 1'b1, "R10 rx irq error", irq, 1);
    wr(5'd20, 8'h06);
    rd(5'd20, v); chk(v == st(1, 0, 0, 1, 1, 0), "R9 write one keeps flag", v, st(1, 0, 0, 1, 1, 0));
    wr(5'd20, 8'h04);
    rd(5'd20, v); chk(v == st(1, 0, 0, 1, 0, 0), "R9 write zero clears", v, st(1, 0, 0, 1, 0, 0));
    chk(irq == 1'b0, "R10 rx irq cleared", irq, 0);

    // R7 frame error
    sendRx(8'h77, 1'b0, 1);
    rd(5'd20, v); chk(v == st(1, 0, 1, 1, 0, 1), "R7 frame error", v, st(1, 0, 1, 1, 0, 1));
    rd(5'd16, v); chk(v == 8'h77, "R7 char kept", v, 8'h77);
    wr(5'd20, 8'h04);
    rd(5'd20, v); chk(v == st(1, 0, 0, 1, 0, 0), "R9 frame clear", v, st(1, 0, 0, 1, 0, 0));

    // R9 read-only bits
    wr(5'd20, 8'hBC);
    rd(5'd20, v); chk(v == st(1, 0, 0, 1, 0, 0), "R9 read-only bits", v, st(1, 0, 0, 1, 0, 0));

    // R10 receive irq off with data queued
    wr(5'd20, 8'h00);
    sendRx(8'h42, 1'b1, 1);
    chk(irq == 1'b0, "R10 rx irq disabled", irq, 0);
    rd(5'd20, v); chk(v == st(1, 0, 1, 0, 0, 0), "R3 one entry", v, st(1, 0, 1, 0, 0, 0));
    rd(5'd16, v); chk(v == 8'h42, "R8 pop", v, 8'h42);

    // R11 short low pulse rejected
    @(negedge clk); rxIn = 1'b0;
    repeat (2) @(negedge clk); rxIn = 1'b1;
    repeat (100) @(negedge clk);
    rd(5'd20, v); chk(v == st(1, 0, 0, 0, 0, 0), "R11 glitch rejected", v, st(1, 0, 0, 0, 0, 0));

    // R2 misaligned access
    wr(5'd25, 8'h77);
    rd(5'd24, v); chk(v == 8'h01, "R2 misaligned write", v, 8'h01);
    rd(5'd21, v); chk(v == 8'h00, "R2 misaligned read", v, 8'h00);

    // R8 receive sweep: all values at divisor 0, a subset at divisor 2
    setDiv(0);
    for (int b = 0; b < 256; b++) begin
      sendRx(8'(b), 1'b1, 0);
      rd(5'd16, v); chk(v == 8'(b), "R8 rx sweep div0", v, 8'(b));
    end
    setDiv(2);
    for (int b = 0; b < 256; b += 15) begin
      sendRx(8'(b), 1'b1, 2);
      rd(5'd16, v); chk(v == 8'(b), "R8 rx sweep div2", v, 8'(b));
    end
    rd(5'd20, v); chk(v == st(1, 0, 0, 0, 0, 0), "R3 empty at end", v, st(1, 0, 0, 0, 0, 0));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule